// File: doc/BRIEF.md
# Stack Push, Pop, Call and Return Sequencer

This block carries out the four stack operations of a simple processor against a word-wide data memory port. It owns the stack pointer, which grows toward lower addresses in steps of one word (8 bytes for the default 64-bit word). A push lowers the pointer first and then stores the word at the new pointer. A pop reads the word at the current pointer and then raises the pointer. Call and return reuse these two sequences. A call stores the address of the next sequential instruction and redirects the program counter to a target. A return fetches an address from the stack and redirects the program counter to it.

The decoder presents a request with an operation code and operands. The block accepts it only when idle, issues one memory request and holds it until the memory answers ready. It then updates its state and raises `done` for a single cycle. The surrounding pipeline writes the popped word into its register file from `popData` and takes the new program counter from `pcOut` when `pcLoad` is high. An error answer from memory cancels the operation and leaves the pointer and program counter untouched.

Top module: `stk_call_seq`

## Requirements
- R1: While `rstN` is low at a clock edge, the stack pointer takes the parameter value `SP_RESET`, and `busy`, `done`, `fault` and `pcLoad` are low after that edge.
- R2: Operation code 2'b00 (push) writes `pushData` to address SP-8 with `memWe` high, and the stack pointer becomes SP-8 once memory answers without error.
- R3: Operation code 2'b01 (pop) reads address SP with `memRe` high, puts the returned word on `popData` and raises the stack pointer to SP+8.
- R4: Operation code 2'b10 (call) writes `nextPc` to address SP-8 and lowers the stack pointer to SP-8. `pcOut` becomes `targetPc` and `pcLoad` is high in the `done` cycle.
- R5: Operation code 2'b11 (return) reads address SP and raises the stack pointer to SP+8. `pcOut` and `popData` both become the word read, and `pcLoad` is high in the `done` cycle.
- R6: After a request is accepted, the memory strobe, address and write data stay unchanged until the cycle in which `memReady` is high. `memWe` and `memRe` are never high together, and neither is high while `busy` is low.
- R7: `done` is high for exactly one cycle, the cycle after the one in which `memReady` was high. `busy` is high from the cycle after acceptance through the `done` cycle.
- R8: A request presented while `busy` is high is ignored. It changes neither the stack pointer nor memory, and no further operation runs.
- R9: If `memErr` is high together with `memReady`, `done` and `fault` are high in the next cycle. The stack pointer and `pcOut` keep their values, `pcLoad` stays low and memory is not written.
- R10: `misaligned` is high exactly when the low three bits of the stack pointer are not all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| opValid | input | 1 | Operation request |
| opCode | input | 2 | 00 push, 01 pop, 10 call, 11 return |
| pushData | input | WORD_W | Word to push |
| nextPc | input | WORD_W | Address of the next sequential instruction (call) |
| targetPc | input | WORD_W | Call target |
| memAddr | output | WORD_W | Memory byte address |
| memWdata | output | WORD_W | Memory write data |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| memReady | input | 1 | Memory answer valid |
| memErr | input | 1 | Memory error, qualified by memReady |
| memRdata | input | WORD_W | Memory read data |
| popData | output | WORD_W | Last word read by pop or return |
| pcOut | output | WORD_W | Redirected program counter |
| pcLoad | output | 1 | pcOut to be taken, with done |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Operation cancelled by memory error, with done |
| busy | output | 1 | Operation in progress |
| spOut | output | WORD_W | Current stack pointer |
| misaligned | output | 1 | Stack pointer not word aligned |

## Verification
The main instance is built with the default 64-bit word and `SP_RESET` = 0x80. With that value, sixteen pushes run the pointer all the way down to address zero, so the bench's sixteen-word memory model covers the whole stack. Every depth is then exercised by pushes, pops, calls and returns under memory latencies of zero to three wait cycles. A second instance uses `SP_RESET` = 0x84, which makes the misaligned indication reachable.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_CALL = 2'b10,
    OP_RET  = 2'b11
  } stkOp_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_FIN  = 2'b10
  } stkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch request operands
    logic issue;    // drive the memory request
    logic commit;   // memory answered cleanly, update state
  } stkCtl_t;
endpackage

// File: rtl/stk_control.sv
module stk_control
  import stk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    opValid,
  input  logic    memReady,
  input  logic    memErr,
  output stkCtl_t ctl,
  output logic    done,
  output logic    fault,
  output logic    busy
);
  stkState_e state;
  logic      errReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      errReg <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (opValid) state <= ST_REQ;
        ST_REQ: begin
          if (memReady) begin
            state  <= ST_FIN;
            errReg <= memErr;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.capture = (state == ST_IDLE) && opValid;
    ctl.issue   = (state == ST_REQ);
    ctl.commit  = (state == ST_REQ) && memReady && !memErr;
  end

  assign done  = (state == ST_FIN);
  assign fault = (state == ST_FIN) && errReg;
  assign busy  = (state != ST_IDLE);
endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int              WORD_W   = 64,
  parameter logic [WORD_W-1:0] SP_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  stkCtl_t           ctl,
  input  stkOp_e            reqOp,
  input  logic [WORD_W-1:0] pushData,
  input  logic [WORD_W-1:0] nextPc,
  input  logic [WORD_W-1:0] targetPc,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  output logic [WORD_W-1:0] popData,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] spOut,
  output logic              misaligned,
  output stkOp_e            curOp
);
  localparam int              STEP_BYTES = WORD_W / 8;
  localparam logic [WORD_W-1:0] STEP     = WORD_W'(STEP_BYTES);
  localparam int              ALIGN_W    = $clog2(STEP_BYTES);

  logic [WORD_W-1:0] sp;
  logic [WORD_W-1:0] wordReg;
  logic [WORD_W-1:0] tgtReg;
  stkOp_e            opReg;
  logic              isWrite;
  logic [WORD_W-1:0] spDown;
  logic [WORD_W-1:0] spUp;

  assign spDown  = sp - STEP;
  assign spUp    = sp + STEP;
  assign isWrite = (opReg == OP_PUSH) || (opReg == OP_CALL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp      <= SP_RESET;
      opReg   <= OP_PUSH;
      wordReg <= '0;
      tgtReg  <= '0;
      popData <= '0;
      pcOut   <= '0;
    end else begin
      if (ctl.capture) begin
        opReg   <= reqOp;
        wordReg <= (reqOp == OP_CALL) ? nextPc : pushData;
        tgtReg  <= targetPc;
      end
      if (ctl.commit) begin
        unique case (opReg)
          OP_PUSH: sp <= spDown;
          OP_POP: begin
            sp      <= spUp;
            popData <= memRdata;
          end
          OP_CALL: begin
            sp    <= spDown;
            pcOut <= tgtReg;
          end
          OP_RET: begin
            sp      <= spUp;
            popData <= memRdata;
            pcOut   <= memRdata;
          end
          default: sp <= sp;
        endcase
      end
    end
  end

  assign memWe    = ctl.issue && isWrite;
  assign memRe    = ctl.issue && !isWrite;
  assign memAddr  = ctl.issue ? (isWrite ? spDown : sp) : '0;
  assign memWdata = memWe ? wordReg : '0;

  assign spOut      = sp;
  assign misaligned = |sp[ALIGN_W-1:0];
  assign curOp      = opReg;
endmodule

// File: rtl/stk_call_seq.sv
module stk_call_seq
  import stk_pkg::*;
#(
  parameter int              WORD_W   = 64,
  parameter logic [WORD_W-1:0] SP_RESET = WORD_W'(64'h1000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opCode,
  input  logic [WORD_W-1:0] pushData,
  input  logic [WORD_W-1:0] nextPc,
  input  logic [WORD_W-1:0] targetPc,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic              memReady,
  input  logic              memErr,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] popData,
  output logic [WORD_W-1:0] pcOut,
  output logic              pcLoad,
  output logic              done,
  output logic              fault,
  output logic              busy,
  output logic [WORD_W-1:0] spOut,
  output logic              misaligned
);
  stkCtl_t ctl;
  stkOp_e  curOp;

  stk_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .memReady(memReady),
    .memErr  (memErr),
    .ctl     (ctl),
    .done    (done),
    .fault   (fault),
    .busy    (busy)
  );

  stk_datapath #(.WORD_W(WORD_W), .SP_RESET(SP_RESET)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqOp     (stkOp_e'(opCode)),
    .pushData  (pushData),
    .nextPc    (nextPc),
    .targetPc  (targetPc),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memWe     (memWe),
    .memRe     (memRe),
    .popData   (popData),
    .pcOut     (pcOut),
    .spOut     (spOut),
    .misaligned(misaligned),
    .curOp     (curOp)
  );

  assign pcLoad = done && !fault && ((curOp == OP_CALL) || (curOp == OP_RET));
endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              memWe,
  input logic              memRe,
  input logic              memReady,
  input logic [WORD_W-1:0] memAddr,
  input logic [WORD_W-1:0] memWdata,
  input logic              done,
  input logic              fault,
  input logic              busy,
  input logic              pcLoad,
  input logic [WORD_W-1:0] spOut,
  input logic [WORD_W-1:0] pcOut
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWe, memRe}));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(memWe || memRe));

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) && !memReady |=>
      (memWe || memRe) && $stable(memAddr) && $stable(memWdata) && $stable(memWe));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memReady) && busy);

  assert_sp_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spOut) |-> (spOut == $past(spOut) - STEP) || (spOut == $past(spOut) + STEP));

  assert_fault_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> $stable(spOut) && $stable(pcOut) && !pcLoad);

  assert_pcload_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> done);
endmodule

bind stk_call_seq stk_checker #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memWe   (memWe),
  .memRe   (memRe),
  .memReady(memReady),
  .memAddr (memAddr),
  .memWdata(memWdata),
  .done    (done),
  .fault   (fault),
  .busy    (busy),
  .pcLoad  (pcLoad),
  .spOut   (spOut),
  .pcOut   (pcOut)
);

// File: tb/sim_stk_call_seq.sv
`timescale 1ns/1ps
module sim_stk_call_seq;
  localparam int          W      = 64;
  localparam logic [W-1:0] SP0   = 64'h80;
  localparam int          DEPTH  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [1:0] opCode = 2'b00;
  logic [W-1:0] pushData = '0, nextPc = '0, targetPc = '0;
  logic [W-1:0] memAddr, memWdata, memRdata = '0;
  logic memWe, memRe;
  logic memReady = 1'b0, memErr = 1'b0;
  logic [W-1:0] popData, pcOut, spOut;
  logic pcLoad, done, fault, busy, misaligned;

  logic [W-1:0] u1Addr, u1Wdata, u1Pop, u1Pc, u1Sp;
  logic u1We, u1Re, u1PcLoad, u1Done, u1Fault, u1Busy, u1Mis;

  int errors = 0;
  int checks = 0;
  int latency = 0;
  int waitCnt = 0;
  logic errNext = 1'b0;
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] lastAddr;
  logic lastWe, lastRe;
  logic [W-1:0] expSp;
  logic [W-1:0] expPc;

  always #5 clk = ~clk;

  stk_call_seq #(.WORD_W(W), .SP_RESET(SP0)) u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .pushData(pushData), .nextPc(nextPc), .targetPc(targetPc),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .memReady(memReady), .memErr(memErr), .memRdata(memRdata),
    .popData(popData), .pcOut(pcOut), .pcLoad(pcLoad), .done(done),
    .fault(fault), .busy(busy), .spOut(spOut), .misaligned(misaligned)
  );

  stk_call_seq #(.WORD_W(W), .SP_RESET(64'h84)) u1 (
    .clk(clk), .rstN(rstN), .opValid(1'b0), .opCode(2'b00),
    .pushData('0), .nextPc('0), .targetPc('0),
    .memAddr(u1Addr), .memWdata(u1Wdata), .memWe(u1We), .memRe(u1Re),
    .memReady(1'b0), .memErr(1'b0), .memRdata('0),
    .popData(u1Pop), .pcOut(u1Pc), .pcLoad(u1PcLoad), .done(u1Done),
    .fault(u1Fault), .busy(u1Busy), .spOut(u1Sp), .misaligned(u1Mis)
  );

  // memory model: answers after `latency` wait cycles
  always @(negedge clk) begin
    if (memWe || memRe) begin
      lastAddr = memAddr;
      lastWe   = memWe;
      lastRe   = memRe;
      if (waitCnt >= latency) begin
        memReady = 1'b1;
        memErr   = errNext;
        memRdata = mem[(memAddr >> 3) % DEPTH];
      end else begin
        memReady = 1'b0;
        waitCnt  = waitCnt + 1;
      end
    end else begin
      memReady = 1'b0;
      memErr   = 1'b0;
      waitCnt  = 0;
    end
  end

  always @(posedge clk) begin
    if (memWe && memReady && !memErr) mem[(memAddr >> 3) % DEPTH] <= memWdata;
  end

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // issue one op; returns at the negedge where done is high
  task automatic runOp(input logic [1:0] op, input logic [W-1:0] d,
                       input logic [W-1:0] nx, input logic [W-1:0] tg,
                       input bit hammer);
    @(negedge clk);
    opValid = 1'b1; opCode = op; pushData = d; nextPc = nx; targetPc = tg;
    @(negedge clk);
    check("R7", "busy after accept", W'(busy), W'(1));
    if (hammer) begin
      opCode = 2'b01; pushData = ~d;
    end else begin
      opValid = 1'b0;
    end
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
    opValid = 1'b0;
    check("R7", "done reached", W'(done), W'(1));
  endtask

  task automatic doPush(input logic [W-1:0] d);
    runOp(2'b00, d, '0, '0, 1'b0);
    check("R2", "write strobe", W'(lastWe), W'(1));
    check("R2", "write addr", lastAddr, expSp - 8);
    expSp = expSp - 8;
    check("R2", "sp lowered", spOut, expSp);
    check("R2", "stored word", mem[(expSp >> 3) % DEPTH], d);
  endtask

  task automatic doPop(input logic [W-1:0] expWord);
    runOp(2'b01, '0, '0, '0, 1'b0);
    check("R3", "read strobe", W'(lastRe), W'(1));
    check("R3", "read addr", lastAddr, expSp);
    check("R3", "popped word", popData, expWord);
    expSp = expSp + 8;
    check("R3", "sp raised", spOut, expSp);
    check("R3", "no pcLoad", W'(pcLoad), W'(0));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [W-1:0] vals [DEPTH];
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expSp = SP0;
    check("R1", "reset sp", spOut, SP0);
    check("R1", "reset busy", W'(busy), W'(0));
    check("R1", "reset done", W'(done), W'(0));
    check("R1", "reset pcLoad", W'(pcLoad), W'(0));
    check("R10", "aligned flag", W'(misaligned), W'(0));
    check("R10", "misaligned flag", W'(u1Mis), W'(1));

    // full-depth sweep with varying latency
    for (int i = 0; i < DEPTH; i++) begin
      latency = i % 4;
      vals[i] = {32'hA5A5_0000 + 32'(i), 32'(i * 7919)};
      doPush(vals[i]);
    end
    check("R2", "sp at bottom", spOut, '0);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      latency = (i + 1) % 4;
      doPop(vals[i]);
    end
    check("R3", "sp back at top", spOut, SP0);

    // call / return at several depths
    for (int k = 0; k < 4; k++) begin
      latency = k;
      for (int j = 0; j < k; j++) doPush(W'(j + 100));
      runOp(2'b10, '0, W'(64'h4000 + k * 16), W'(64'h9000 + k), 1'b0);
      check("R4", "write addr", lastAddr, expSp - 8);
      expSp = expSp - 8;
      check("R4", "sp lowered", spOut, expSp);
      check("R4", "return addr stored", mem[(expSp >> 3) % DEPTH], W'(64'h4000 + k * 16));
      check("R4", "pc target", pcOut, W'(64'h9000 + k));
      check("R4", "pcLoad", W'(pcLoad), W'(1));
      runOp(2'b11, '0, '0, '0, 1'b0);
      check("R5", "read addr", lastAddr, expSp);
      expSp = expSp + 8;
      check("R5", "sp raised", spOut, expSp);
      check("R5", "pc from stack", pcOut, W'(64'h4000 + k * 16));
      check("R5", "popData", popData, W'(64'h4000 + k * 16));
      check("R5", "pcLoad", W'(pcLoad), W'(1));
      for (int j = k - 1; j >= 0; j--) doPop(W'(j + 100));
    end

    // requests while busy are ignored
    latency = 3;
    runOp(2'b00, 64'hDEAD_BEEF, '0, '0, 1'b1);
    expSp = expSp - 8;
    check("R8", "sp one push only", spOut, expSp);
    @(negedge clk);
    @(negedge clk);
    check("R8", "idle after", W'(busy), W'(0));
    check("R8", "sp unchanged", spOut, expSp);
    check("R8", "top word kept", mem[(expSp >> 3) % DEPTH], 64'hDEAD_BEEF);
    doPop(64'hDEAD_BEEF);

    // memory error aborts
    expPc = pcOut;
    mem[((expSp - 8) >> 3) % DEPTH] = 64'h1111;
    errNext = 1'b1;
    for (int k = 0; k < 4; k++) begin
      latency = k;
      runOp(2'(k), 64'h7777, 64'h5555, 64'h6666, 1'b0);
      check("R9", "fault", W'(fault), W'(1));
      check("R9", "no pcLoad", W'(pcLoad), W'(0));
      check("R9", "sp kept", spOut, expSp);
      check("R9", "pc kept", pcOut, expPc);
      check("R9", "no write", mem[((expSp - 8) >> 3) % DEPTH], 64'h1111);
      @(negedge clk);
      check("R7", "done pulse ended", W'(done), W'(0));
    end
    errNext = 1'b0;
    doPush(64'h2222);
    check("R9", "recovers", W'(fault), W'(0));
    doPop(64'h2222);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule